// File: doc/BRIEF.md
# Asynchronous Fetch-and-Add Command Engine

This engine lets a requester issue an atomic fetch-and-add and carry on without waiting for the result. The requester sends one 64-bit command word. The engine decodes it and issues the add to an external counter store through a valid/ready request channel. When the store responds, the engine writes a 64-bit result word into a local scratchpad, at the slot that the command names.

The counter store returns responses in the order it received requests. The engine keeps a small in-order table of outstanding commands, so that each response can be routed to its own scratchpad slot. The table also records how wide each result is, so the engine can widen narrower results. When the table is full, the command input stalls.

A command can ask the store to wait for a pending tag switch before it adds. If that wait times out, the store flags the response, and the engine writes a word whose top bit marks the result as invalid.

Top module: `async_fadd_engine`

## Requirements
- R1: An accepted command with length field bits 55:48 equal to 1 is issued to the store in the cycle it is accepted. The request carries the register byte address from bits 10:0, the size code from bits 12:11, the 22-bit signed increment from bits 35:14 and the tag-wait flag from bit 13.
- R2: Each store response causes exactly one scratchpad write in the next cycle. The write goes to the 8-byte slot given by bits 63:56 of the originating command.
- R3: For a response that did not time out, bit 63 of the written word is 0. Bits 62:0 hold the pre-update value sign-extended from its width: size code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 gives the low 63 bits of a 64-bit value.
- R4: For a response flagged as a timeout, the written word has bit 63 set and bits 62:0 cleared.
- R5: A command whose length field is not 1 is still accepted, but it issues no request and never leads to a scratchpad write. It raises `err_pulse` for one cycle, in the cycle after acceptance.
- R6: At most DEPTH (default 4) commands are outstanding at once. `cmd_ready` is low while DEPTH are outstanding, and also while the store deasserts `req_ready`.
- R7: Scratchpad writes occur in the order in which the commands were accepted.
- R8: After reset, `sp_we` and `err_pulse` are low and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command accepted on this edge if valid |
| cmd_word | input | 64 | Encoded fetch-and-add command |
| err_pulse | output | 1 | One-cycle pulse for a rejected length field |
| req_valid | output | 1 | Atomic request to the counter store |
| req_ready | input | 1 | Store can take a request |
| req_addr | output | 11 | Counter register byte address |
| req_size | output | 2 | Operand size code |
| req_incr | output | 22 | Signed increment |
| req_wait | output | 1 | Wait for tag switch before the add |
| resp_valid | input | 1 | Store response present (in request order) |
| resp_data | input | 64 | Pre-update value, zero above the operand width |
| resp_timeout | input | 1 | Tag-wait timed out; data meaningless |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_addr | output | 8 | Scratchpad slot in 8-byte units |
| sp_wdata | output | 64 | Result word |

## Verification
The hardest state to reach is a full outstanding table, because the store model normally drains responses as soon as requests arrive. The bench can hold responses back while it queues commands. It also throttles responses on a fixed pattern during the sweep. Together these fill the table, show `cmd_ready` low, and make table pointers wrap while responses land in varying cycles. The sweep covers all four sizes, increments at the 22-bit limits, and both waiting and timing-out tag-wait commands on shared counters, so that carries and sign extension are exercised against values accumulated in the bench.

// File: rtl/async_fadd_engine.sv
module async_fadd_engine #(
  parameter int DEPTH = 4,
  parameter int SPW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [63:0]    cmd_word,
  output logic           err_pulse,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [10:0]    req_addr,
  output logic [1:0]     req_size,
  output logic [21:0]    req_incr,
  output logic           req_wait,
  input  logic           resp_valid,
  input  logic [63:0]    resp_data,
  input  logic           resp_timeout,
  output logic           sp_we,
  output logic [SPW-1:0] sp_addr,
  output logic [63:0]    sp_wdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [SPW-1:0] q_slot [DEPTH];
  logic [1:0]     q_size [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;

  wire len_ok   = cmd_word[55:48] == 8'd1;
  wire has_room = count < CW'(DEPTH);
  wire accept   = cmd_valid && cmd_ready;
  wire push     = accept && len_ok;
  wire pop      = resp_valid;

  assign cmd_ready = has_room && req_ready;
  assign req_valid = cmd_valid && len_ok && has_room;
  assign req_addr  = cmd_word[10:0];
  assign req_wait  = cmd_word[13];
  assign req_size  = cmd_word[12:11];
  assign req_incr  = cmd_word[35:14];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [62:0] widen(input logic [63:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return {{55{v[7]}},  v[7:0]};
      2'd1:    return {{47{v[15]}}, v[15:0]};
      2'd2:    return {{31{v[31]}}, v[31:0]};
      default: return v[62:0];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      q_slot[wr_ptr] <= cmd_word[56 +: SPW];
      q_size[wr_ptr] <= cmd_word[12:11];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      sp_we     <= 1'b0;
      err_pulse <= 1'b0;
      sp_addr   <= '0;
      sp_wdata  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count     <= count + CW'(push) - CW'(pop);
      err_pulse <= accept && !len_ok;
      sp_we     <= pop;
      if (pop) begin
        sp_addr  <= q_slot[rd_ptr];
        sp_wdata <= resp_timeout ? {1'b1, 63'd0}
                                 : {1'b0, widen(resp_data, q_size[rd_ptr])};
      end
    end
  end

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !cmd_ready);
  // R7
  resp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> count != '0);
  // R2
  write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> sp_we);
  // R4
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_timeout) |=> (sp_wdata[63] && sp_wdata[62:0] == '0));
  // R5
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_word[55:48] != 8'd1) |=> err_pulse);
  // R5
  no_bad_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cmd_word[55:48] == 8'd1);
endmodule

// File: tb/async_fadd_engine_bench.sv
module async_fadd_engine_bench;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, req_ready_tb = 1, hold_resp = 1;
  logic [63:0] cmd_word = '0;
  logic cmd_ready, err_pulse, req_valid, req_wait, resp_valid, resp_timeout, sp_we;
  logic [10:0] req_addr;
  logic [1:0] req_size;
  logic [21:0] req_incr;
  logic [63:0] resp_data, sp_wdata;
  logic [7:0] sp_addr;

  int checks = 0, fails = 0, cyc = 0, n_exp = 0, n_wr = 0, wr = 0, rd = 0;
  logic [63:0] mem [2048];
  logic [63:0] refm [2048];
  logic [63:0] rq_data [16];
  logic rq_to [16];
  logic [7:0] ex_addr [512];
  logic [63:0] ex_data [512];
  logic [7:0] lg_addr [512];
  logic [63:0] lg_data [512];

  always #(CLK_NS/2) clk = ~clk;

  async_fadd_engine #(.DEPTH(DEPTH), .SPW(8)) u_async_fadd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .err_pulse(err_pulse), .req_valid(req_valid),
    .req_ready(req_ready_tb), .req_addr(req_addr), .req_size(req_size),
    .req_incr(req_incr), .req_wait(req_wait), .resp_valid(resp_valid),
    .resp_data(resp_data), .resp_timeout(resp_timeout), .sp_we(sp_we),
    .sp_addr(sp_addr), .sp_wdata(sp_wdata));

  function automatic logic [63:0] mask_of(input logic [1:0] s);
    case (s)
      2'd0: return 64'hFF;
      2'd1: return 64'hFFFF;
      2'd2: return 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] sx22(input logic [21:0] v);
    return {{42{v[21]}}, v};
  endfunction

  assign resp_valid   = !hold_resp && (cyc % 3 != 0) && (wr != rd);
  assign resp_data    = rq_data[rd % 16];
  assign resp_timeout = rq_to[rd % 16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (resp_valid) rd <= rd + 1;
    if (req_valid && req_ready_tb) begin
      logic [63:0] m, o;
      logic t;
      m = mask_of(req_size);
      o = mem[req_addr] & m;
      t = req_wait && req_addr[10];
      rq_data[wr % 16] <= o;
      rq_to[wr % 16] <= t;
      if (!t) mem[req_addr] <= (mem[req_addr] & ~m) | ((o + sx22(req_incr)) & m);
      wr <= wr + 1;
    end
    if (sp_we) begin
      lg_addr[n_wr] <= sp_addr;
      lg_data[n_wr] <= sp_wdata;
      n_wr <= n_wr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] slot, input logic [7:0] len, input logic [21:0] inc,
                      input logic w, input logic [1:0] sz, input logic [10:0] a);
    logic [63:0] m, o, e;
    logic t;
    @(negedge clk);
    cmd_word = {slot, len, 12'd0, inc, w, sz, a};
    cmd_valid = 1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    if (len == 8'd1) begin
      // R1 decode of the request fields
      check(req_valid && req_addr == a && req_size == sz && req_incr == inc && req_wait == w,
            "R1", {req_valid, req_wait, req_size, req_incr, req_addr},
            {1'b1, w, sz, inc, a});
      m = mask_of(sz);
      o = refm[a] & m;
      t = w && a[10];
      if (!t) refm[a] = (refm[a] & ~m) | ((o + sx22(inc)) & m);
      case (sz)
        2'd0: e = {1'b0, {55{o[7]}}, o[7:0]};
        2'd1: e = {1'b0, {47{o[15]}}, o[15:0]};
        2'd2: e = {1'b0, {31{o[31]}}, o[31:0]};
        default: e = {1'b0, o[62:0]};
      endcase
      if (t) e = {1'b1, 63'd0};
      ex_addr[n_exp] = slot;
      ex_data[n_exp] = e;
      n_exp++;
    end else begin
      // R5 rejected length issues nothing
      check(!req_valid, "R5", 64'(req_valid), 64'd0);
    end
    @(negedge clk);
    cmd_valid = 0;
    // R5 error pulse only for bad length
    check(err_pulse == (len != 8'd1), "R5", 64'(err_pulse), 64'(len != 8'd1));
  endtask

  task automatic drain;
    int g = 0;
    while (n_wr < n_exp && g < 2000) begin @(negedge clk); g++; end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [21:0] incs [7];
    incs = '{22'd0, 22'd1, 22'h3FFFFF, 22'd127, 22'h3FFF80, 22'h1FFFFF, 22'h200000};
    for (int a = 0; a < 2048; a++) begin
      mem[a]  = 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
      refm[a] = 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!sp_we && !err_pulse && !req_valid && cmd_ready, "R8",
          {sp_we, err_pulse, req_valid, cmd_ready}, 64'b0001);
    rst_n = 1;

    // R6 full table stalls the command input
    for (int i = 0; i < DEPTH; i++) send(8'(200 + i), 8'd1, 22'd3, 1'b0, 2'd3, 11'(i * 8));
    @(negedge clk); #1;
    check(!cmd_ready, "R6", 64'(cmd_ready), 64'd0);
    hold_resp = 0;
    drain();
    req_ready_tb = 0;
    #1;
    check(!cmd_ready, "R6", 64'(cmd_ready), 64'd0);
    req_ready_tb = 1;

    // R5 bad lengths
    send(8'd10, 8'd0, 22'd5, 1'b0, 2'd0, 11'd8);
    send(8'd11, 8'd2, 22'd5, 1'b0, 2'd0, 11'd8);
    send(8'd12, 8'd255, 22'd5, 1'b1, 2'd2, 11'd1032);

    // R3 R4 sweep of sizes, increments and tag-wait variants
    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 7; k++)
        for (int v = 0; v < 4; v++) begin
          logic [10:0] a;
          a = 11'(((k + v) % 8) * 8) | ((v >= 2) ? 11'd1024 : 11'd0);
          send(8'(n_exp * 7), 8'd1, incs[k], v[0], 2'(sz), a);
        end
    drain();

    // R2 R3 R4 R7 every write matches its command, in order
    check(n_wr == n_exp, "R5", 64'(n_wr), 64'(n_exp));
    for (int i = 0; i < n_exp; i++) begin
      check(lg_addr[i] == ex_addr[i], "R2/R7", 64'(lg_addr[i]), 64'(ex_addr[i]));
      check(lg_data[i] == ex_data[i], ex_data[i][63] ? "R4" : "R3", lg_data[i], ex_data[i]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule